// File: doc/BRIEF.md
# Phase-Hitless Reference Switch Corrector

This block sits in front of a digital PLL phase detector. It turns a raw reference phase (a timestamp count taken modulo one reference period) into a virtual reference by subtracting a stored time-interval-error offset. It then reports the signed phase error between that virtual reference and the loop feedback phase. The loop filter only ever sees the corrected error, so a change of input reference or a return from holdover does not show up as a phase step at the loop.

The block has three states: holdover, acquire and tracking. While the loop is held over, the error output is zero and the error-valid flag is low, so the downstream filter freezes. On entry to Normal mode, a select input decides the next step. One choice recaptures the offset on the next reference edge, which costs a bounded measurement error. The other keeps the old offset, so any drift that built up during holdover is pulled back to the original alignment and repeated outages never accumulate. After reset no offset exists yet, so the first Normal entry always recaptures.

Top module: `tie_corrector`

## Requirements
- R1: While reset is high and on the first cycle after it, inHoldover is 1, errValid is 0 and phaseErr is 0. The stored offset is cleared.
- R2: With normalMode at 0 (Holdover), inHoldover is 1 from the next clock edge. While inHoldover is 1, errValid stays 0, phaseErr stays 0 and refValid pulses have no effect.
- R3: The first Normal entry after reset (normalMode going 1 while in holdover) always enters acquire, whatever the value of recapture.
- R4: In acquire, a refValid pulse with normalMode at 1 stores offset = signed wrap of (refPhase - fbPhase). One cycle later it gives errValid 1, phaseErr 0 and virtPhase equal to fbPhase, so there is no phase step.
- R5: In tracking, a refValid pulse with normalMode at 1 gives, one cycle later, errValid 1, virtPhase = (refPhase - offset) mod PERIOD and phaseErr = signed wrap of (virtPhase - fbPhase). Without a refValid pulse, errValid is 0.
- R6: On a Normal entry with recapture at 0 and an offset already held, the block goes straight to tracking and reuses the old offset. The phase error then measures the full drift back to the pre-holdover alignment.
- R7: On a Normal entry with recapture at 1, the block enters acquire and recaptures the offset on the first refValid pulse.
- R8: Leaving Normal for Holdover leaves the stored offset unchanged.
- R9: The signed wrap maps a count d in [0, PERIOD) to d if d < PERIOD/2 and to d - PERIOD otherwise. phaseErr and the offset stay in that range, and virtPhase stays below PERIOD.
- R10: recapture is sampled only in the cycle of Normal entry. Changing it during tracking causes no recapture.
- R11: If normalMode drops during acquire before any refValid pulse, the block returns to holdover and captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| normalMode | input | 1 | 1 = Normal, 0 = Holdover |
| recapture | input | 1 | 1 = recompute the offset on Normal entry, 0 = keep the old offset |
| refValid | input | 1 | Reference edge strobe qualifying refPhase and fbPhase |
| refPhase | input | PHASE_W | Reference phase count, below PERIOD |
| fbPhase | input | PHASE_W | Feedback phase count, below PERIOD |
| virtPhase | output | PHASE_W | Corrected virtual reference phase |
| phaseErr | output | PHASE_W+1 | Signed phase error fed to the phase detector path |
| errValid | output | 1 | phaseErr is a fresh sample |
| inHoldover | output | 1 | Block is in the holdover state |

## Verification
A stored offset that is wrong is invisible until the next tracking reference edge. It then shows one cycle later as a constant bias in phaseErr and virtPhase, so each Normal entry with the offset kept is followed at once by an edge whose error has a known expected value. A wrong state shows up sooner: the error flag pulses during holdover, or the first error after entry is nonzero when a recapture was due, or zero when the old offset was meant to be kept. Wrap errors only appear for phases near the period boundary and near half a period, so directed cases sit there and random phases cover the rest.

// File: rtl/tie_pkg.sv
package tie_pkg;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_ACQ  = 2'd1,
    ST_RUN  = 2'd2
  } tieState_e;

  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic capture;  // load a fresh offset from this reference edge
    logic track;    // produce an error using the held offset
  } tieStrobe_t;

endpackage

// File: rtl/tie_ctrl.sv
module tie_ctrl
  import tie_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       normalMode,
  input  logic       recapture,
  input  logic       refValid,
  output tieStrobe_t strobe,
  output logic       inHoldover
);

  tieState_e state, stateNext;
  logic      haveOffset;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_HOLD: begin
        if (normalMode) begin
          stateNext = (!haveOffset || recapture) ? ST_ACQ : ST_RUN;
        end
      end
      ST_ACQ: begin
        if (!normalMode) begin
          stateNext = ST_HOLD;
        end else if (refValid) begin
          strobe.capture = 1'b1;
          stateNext      = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!normalMode) begin
          stateNext = ST_HOLD;
        end else if (refValid) begin
          strobe.track = 1'b1;
        end
      end
      default: stateNext = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_HOLD;
      haveOffset <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.capture) begin
        haveOffset <= 1'b1;
      end
    end
  end

  assign inHoldover = (state == ST_HOLD);

endmodule

// File: rtl/tie_datapath.sv
module tie_datapath
  import tie_pkg::*;
#(
  parameter int PERIOD  = 1000,
  parameter int PHASE_W = $clog2(PERIOD),
  parameter int ERR_W   = PHASE_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  tieStrobe_t              strobe,
  input  logic [PHASE_W-1:0]      refPhase,
  input  logic [PHASE_W-1:0]      fbPhase,
  output logic [PHASE_W-1:0]      virtPhase,
  output logic signed [ERR_W-1:0] phaseErr,
  output logic                    errValid
);

  localparam int WIDE_W = PHASE_W + 2;
  localparam logic signed [WIDE_W-1:0] PERIOD_S = WIDE_W'(PERIOD);
  localparam logic signed [ERR_W-1:0]  PERIOD_E = ERR_W'(PERIOD);
  localparam logic [PHASE_W-1:0]       HALF_U   = PHASE_W'(PERIOD / 2);

  // bring a value in (-PERIOD, 2*PERIOD) back into [0, PERIOD)
  function automatic logic [PHASE_W-1:0] wrapMod(input logic signed [WIDE_W-1:0] x);
    logic signed [WIDE_W-1:0] y;
    y = x;
    if (y < 0) begin
      y = y + PERIOD_S;
    end else if (y >= PERIOD_S) begin
      y = y - PERIOD_S;
    end
    return PHASE_W'(y);
  endfunction

  // map [0, PERIOD) onto the signed window around zero
  function automatic logic signed [ERR_W-1:0] toSigned(input logic [PHASE_W-1:0] d);
    logic signed [ERR_W-1:0] ds;
    ds = signed'({1'b0, d});
    return (d >= HALF_U) ? (ds - PERIOD_E) : ds;
  endfunction

  logic signed [ERR_W-1:0]  offsetReg;
  logic signed [WIDE_W-1:0] refWide, fbWide, offWide;
  logic signed [ERR_W-1:0]  capOffset, offsetUse, errNow;
  logic [PHASE_W-1:0]       virtNow;
  logic                     sampleNow;

  assign refWide   = signed'({2'b00, refPhase});
  assign fbWide    = signed'({2'b00, fbPhase});
  assign capOffset = toSigned(wrapMod(refWide - fbWide));
  assign offsetUse = strobe.capture ? capOffset : offsetReg;
  assign offWide   = WIDE_W'(offsetUse);
  assign virtNow   = wrapMod(refWide - offWide);
  assign errNow    = toSigned(wrapMod(signed'({2'b00, virtNow}) - fbWide));
  assign sampleNow = strobe.capture | strobe.track;

  always_ff @(posedge clk) begin
    if (rst) begin
      offsetReg <= '0;
      virtPhase <= '0;
      phaseErr  <= '0;
      errValid  <= 1'b0;
    end else begin
      if (strobe.capture) begin
        offsetReg <= capOffset;
      end
      errValid <= sampleNow;
      phaseErr <= sampleNow ? errNow : '0;
      if (sampleNow) begin
        virtPhase <= virtNow;
      end
    end
  end

endmodule

// File: rtl/tie_corrector.sv
module tie_corrector
  import tie_pkg::*;
#(
  parameter int PERIOD = 1000,
  localparam int PHASE_W = $clog2(PERIOD),
  localparam int ERR_W   = PHASE_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    normalMode,
  input  logic                    recapture,
  input  logic                    refValid,
  input  logic [PHASE_W-1:0]      refPhase,
  input  logic [PHASE_W-1:0]      fbPhase,
  output logic [PHASE_W-1:0]      virtPhase,
  output logic signed [ERR_W-1:0] phaseErr,
  output logic                    errValid,
  output logic                    inHoldover
);

  tieStrobe_t strobe;

  tie_ctrl uCtrl (
    .clk        (clk),
    .rst        (rst),
    .normalMode (normalMode),
    .recapture  (recapture),
    .refValid   (refValid),
    .strobe     (strobe),
    .inHoldover (inHoldover)
  );

  tie_datapath #(
    .PERIOD  (PERIOD),
    .PHASE_W (PHASE_W),
    .ERR_W   (ERR_W)
  ) uPath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .refPhase  (refPhase),
    .fbPhase   (fbPhase),
    .virtPhase (virtPhase),
    .phaseErr  (phaseErr),
    .errValid  (errValid)
  );

endmodule

// File: rtl/tie_corrector_chk.sv
module tie_corrector_chk
  import tie_pkg::*;
#(
  parameter int PERIOD  = 1000,
  parameter int PHASE_W = $clog2(PERIOD),
  parameter int ERR_W   = PHASE_W + 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    normalMode,
  input logic                    refValid,
  input tieStrobe_t              strobe,
  input logic [PHASE_W-1:0]      virtPhase,
  input logic signed [ERR_W-1:0] phaseErr,
  input logic                    errValid,
  input logic                    inHoldover
);

  localparam int HALF = PERIOD / 2;

  a_r2_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    inHoldover |-> (!errValid && phaseErr == '0));

  a_r2_enter_hold: assert property (@(posedge clk) disable iff (rst)
    !normalMode |=> inHoldover);

  a_r5_no_ref_no_err: assert property (@(posedge clk) disable iff (rst)
    !$past(refValid) |-> !errValid);

  a_r4_capture_zero: assert property (@(posedge clk) disable iff (rst)
    strobe.capture |=> (errValid && phaseErr == '0));

  a_r5_track_valid: assert property (@(posedge clk) disable iff (rst)
    strobe.track |=> errValid);

  a_r9_err_range: assert property (@(posedge clk) disable iff (rst)
    errValid |-> (int'(phaseErr) >= -(PERIOD - HALF) && int'(phaseErr) < HALF));

  a_r9_virt_range: assert property (@(posedge clk) disable iff (rst)
    errValid |-> (int'(virtPhase) < PERIOD));

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.capture, strobe.track}));

endmodule

bind tie_corrector tie_corrector_chk #(.PERIOD(PERIOD)) uChk (
  .clk        (clk),
  .rst        (rst),
  .normalMode (normalMode),
  .refValid   (refValid),
  .strobe     (strobe),
  .virtPhase  (virtPhase),
  .phaseErr   (phaseErr),
  .errValid   (errValid),
  .inHoldover (inHoldover)
);

// File: tb/tb_tie_corrector.sv
module tb_tie_corrector;

  localparam int P  = 1000;
  localparam int PW = $clog2(P);
  localparam int EW = PW + 1;

  localparam int M_HOLD = 0;
  localparam int M_ACQ  = 1;
  localparam int M_RUN  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic normalMode = 1'b0;
  logic recapture = 1'b0;
  logic refValid = 1'b0;
  logic [PW-1:0] refPhase = '0;
  logic [PW-1:0] fbPhase = '0;
  logic [PW-1:0] virtPhase;
  logic signed [EW-1:0] phaseErr;
  logic errValid;
  logic inHoldover;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  int mState = M_HOLD;
  int mOff = 0;
  bit mHave = 1'b0;

  always #2 clk = ~clk;

  tie_corrector #(.PERIOD(P)) dut (
    .clk        (clk),
    .rst        (rst),
    .normalMode (normalMode),
    .recapture  (recapture),
    .refValid   (refValid),
    .refPhase   (refPhase),
    .fbPhase    (fbPhase),
    .virtPhase  (virtPhase),
    .phaseErr   (phaseErr),
    .errValid   (errValid),
    .inHoldover (inHoldover)
  );

  function automatic int wrapM(input int x);
    return ((x % P) + P) % P;
  endfunction

  function automatic int toS(input int d);
    return (d >= P / 2) ? d - P : d;
  endfunction

  task automatic check(input string tag, input bit expV, input int expE,
                       input int expVirt, input bit expH);
    bit bad;
    vectors++;
    bad = (errValid !== expV) || (int'(phaseErr) != expE) || (inHoldover !== expH) ||
          (expV && int'(virtPhase) != expVirt);
    if (bad) begin
      misses++;
      $display("FAIL %s: valid=%0b err=%0d virt=%0d hold=%0b expected valid=%0b err=%0d virt=%0d hold=%0b",
               tag, errValid, int'(phaseErr), int'(virtPhase), inHoldover,
               expV, expE, expVirt, expH);
    end
  endtask

  // drive one cycle at a falling edge, predict, and check at the next falling edge
  task automatic step(input int r, input int f, input bit v, input bit n,
                      input bit rc, input string tag);
    bit expV;
    int expE;
    int expVirt;
    int nextS;
    expV = 1'b0;
    expE = 0;
    expVirt = 0;
    nextS = mState;
    refPhase = PW'(r);
    fbPhase = PW'(f);
    refValid = v;
    normalMode = n;
    recapture = rc;
    case (mState)
      M_HOLD: if (n) nextS = (!mHave || rc) ? M_ACQ : M_RUN;
      M_ACQ: begin
        if (!n) nextS = M_HOLD;
        else if (v) begin
          mOff = toS(wrapM(r - f));
          mHave = 1'b1;
          expV = 1'b1;
          expVirt = wrapM(r - mOff);
          expE = 0;
          nextS = M_RUN;
        end
      end
      default: begin
        if (!n) nextS = M_HOLD;
        else if (v) begin
          expV = 1'b1;
          expVirt = wrapM(r - mOff);
          expE = toS(wrapM(expVirt - f));
        end
      end
    endcase
    mState = nextS;
    @(negedge clk);
    check(tag, expV, expE, expVirt, nextS == M_HOLD);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset held", 1'b0, 0, 0, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", 1'b0, 0, 0, 1'b1);

    step(300, 20, 1, 0, 0, "R2 ref ignored in holdover");
    step(0, 0, 0, 1, 0, "R3 first entry forces acquire");
    step(100, 50, 1, 1, 0, "R4 capture gives zero error");
    step(130, 70, 1, 1, 0, "R5 tracking error");
    step(131, 70, 0, 1, 0, "R5 no edge no error");
    step(400, 10, 1, 0, 0, "R8 drop to holdover");
    step(0, 0, 0, 1, 0, "R6 resume with kept offset");
    step(100, 60, 1, 1, 0, "R6 drift pulled back");
    step(0, 0, 0, 0, 0, "R2 holdover again");
    step(0, 0, 0, 1, 1, "R7 entry with recapture");
    step(100, 60, 1, 1, 1, "R7 recapture zero error");
    step(100, 50, 1, 1, 0, "R7 tracks new offset");
    step(0, 0, 0, 0, 0, "R2 holdover before wrap");
    step(0, 0, 0, 1, 1, "R7 entry for wrap case");
    step(5, 990, 1, 1, 0, "R9 capture across wrap");
    step(995, 10, 1, 1, 0, "R9 negative error wrap");
    step(520, 0, 1, 1, 0, "R9 error at half period");
    step(0, 0, 0, 0, 0, "R2 holdover before abort");
    step(0, 0, 0, 1, 1, "R11 acquire entered");
    step(0, 0, 0, 0, 0, "R11 abort to holdover");
    step(0, 0, 0, 1, 0, "R10 entry without recapture");
    step(700, 100, 1, 1, 1, "R10 late recapture ignored");

    for (int i = 0; i < 3000; i++) begin
      bit n;
      n = (mState == M_HOLD) ? (($urandom % 4) == 0) : (($urandom % 16) != 0);
      step(int'($urandom % P), int'($urandom % P), ($urandom % 3) == 0, n,
           $urandom % 2, "R5 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule